// File: doc/BRIEF.md
# Three-phase center-aligned PWM generator

This block drives three complementary gate-drive pairs (a high-side and a low-side output per phase) from one up/down time base. One switching period has two halves. The counter climbs from 0 to P-1 in the first half, then falls from P-1 back to 0 in the second half, so a period lasts exactly 2·P clocks. A high-side output is on while the counter is below its phase's duty value. Each turn-on edge, on either side, waits for a programmable dead time so the two switches of a pair never overlap.

Software writes the half-period, dead time, sync-pulse width and three duty values into shadow registers through a plain write strobe. The counter only uses active copies of these values, and the active copies are refreshed from the shadows at reload events. By default a reload happens once per period, at its start. When a mode bit is set, a second reload happens at the midpoint, so any parameter may change for the second half and asymmetric patterns become possible. At every reload the block raises a synchronization pulse of programmable width, meant to trigger an ADC. A status output tells which half of the period is running.

The block has no data stream. Every pin is a plain control or status pin, and a register write is accepted in the cycle its strobe is high with no back-pressure.

Top module: `pwm3_gen`

## Requirements
- R1: While `rst_n` is low, all six gate outputs and `sync_o` are 0, `half_o` is 1 and the counter is held. The first clock edge with `rst_n` high starts a period, performs a reload and raises `sync_o`, with `half_o` at 0.
- R2: Address 0 holds the 16-bit half-period P, and a value of 0 acts as 1. In single-update mode, rising edges of `sync_o` are 2·P clocks apart.
- R3: The duty registers sit at address 3 (phase 0), 4 (phase 1) and 5 (phase 2). With zero dead time and 0 < D < P, each high-side pulse lasts 2·D clocks and each low-side pulse lasts 2·P − 2·D clocks.
- R4: A duty of 0 keeps the high side off for the whole period. A duty of P or more keeps the low side off and the high side on.
- R5: Address 1 holds a 10-bit dead time T. Each turn-on edge is delayed by 2·T clocks after the complementary output turns off. High pulses therefore last 2·D − 2·T clocks and low pulses last 2·P − 2·D − 2·T clocks. T = 0 leaves no gap.
- R6: A pulse whose ideal width does not exceed 2·T never appears.
- R7: Address 2 holds an 8-bit sync width W, with a reset value of 39. Each sync pulse lasts W + 1 clocks and rises in the first cycle of the half that was just reloaded.
- R8: In single-update mode, a shadow write made during a period does not change that period. A high pulse that straddles the next period start lasts D_old + D_new clocks.
- R9: Bit 0 at address 6 selects double-update mode and resets to 0. It takes effect immediately, without waiting for a reload. In double-update mode a reload and a sync pulse also occur at the midpoint, so sync rises are P clocks apart and a high pulse that straddles a period start lasts D_second_half + D_next_first_half clocks.
- R10: In double-update mode, a half-period written during the first half sets the length of the second half of that same period.
- R11: `half_o` is 0 for the whole first half and 1 for the whole second half of each period.
- R12: An output whose bit in `en_hi` or `en_lo` is 0 stays low, and the other outputs are unaffected.
- R13: The high-side and low-side outputs of one phase are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1 dead time, 2 sync width, 3..5 duties, 6 mode) |
| wr_data | input | 16 | Write data, low bits used for narrower fields |
| en_hi | input | 3 | Per-phase high-side output enables |
| en_lo | input | 3 | Per-phase low-side output enables |
| pwm_hi | output | 3 | High-side gate drives, bit i is phase i |
| pwm_lo | output | 3 | Low-side gate drives, bit i is phase i |
| sync_o | output | 1 | Synchronization pulse for ADC triggering |
| half_o | output | 1 | 0 in the first half of a period, 1 in the second |

## Verification
In double-update mode, the midpoint reload and the counter's turnaround happen on the same clock edge. The newly loaded half-period must therefore set where the falling count starts. The bench provokes this by writing a new half-period just after a period-start sync. It then judges the result from the spacing of the next two sync rises: the old P for the first half, the new P for the second. A second coincidence occurs when a reload changes the duty while a high pulse is in progress. This is provoked by writing different duty values at the start and at the midpoint, and it is judged by the width of the straddling pulse.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int CNT_W  = 16;
  localparam int DT_W   = 10;
  localparam int SW_W   = 8;
  localparam int NPH    = 3;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PERIOD = 3'd0,
    A_DEAD   = 3'd1,
    A_SYNCW  = 3'd2,
    A_DUTY0  = 3'd3,
    A_DUTY1  = 3'd4,
    A_DUTY2  = 3'd5,
    A_MODE   = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [CNT_W-1:0]          period;
    logic [DT_W-1:0]           dead;
    logic [SW_W-1:0]           sync_w;
    logic [NPH-1:0][CNT_W-1:0] duty;
  } pwm_cfg_t;

  function automatic logic [CNT_W-1:0] last_tick(input logic [CNT_W-1:0] p);
    return (p == '0) ? '0 : p - 1'b1;
  endfunction
endpackage

// File: rtl/pwm3_regfile.sv
module pwm3_regfile
  import pwm3_pkg::*;
#(
  parameter pwm_cfg_t RST_CFG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output pwm_cfg_t          shadow_o,
  output logic              dbl_o
);
  pwm_cfg_t shadow_q;
  logic     dbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= RST_CFG;
      dbl_q    <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_PERIOD) shadow_q.period <= wr_data;
      if (wr_addr == A_DEAD)   shadow_q.dead   <= wr_data[DT_W-1:0];
      if (wr_addr == A_SYNCW)  shadow_q.sync_w <= wr_data[SW_W-1:0];
      if (wr_addr == A_MODE)   dbl_q           <= wr_data[0];
      for (int i = 0; i < NPH; i++) begin
        if (wr_addr == ADDR_W'(int'(A_DUTY0) + i)) shadow_q.duty[i] <= wr_data;
      end
    end
  end

  assign shadow_o = shadow_q;
  assign dbl_o    = dbl_q;
endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
  import pwm3_pkg::*;
#(
  parameter pwm_cfg_t RST_CFG = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  pwm_cfg_t                  shadow_i,
  input  logic                      dbl_i,
  output logic [CNT_W-1:0]          cnt_o,
  output logic                      half_o,
  output logic                      sync_o,
  output logic [CNT_W-1:0]          period_o,
  output logic [DT_W-1:0]           dead_o,
  output logic [NPH-1:0][CNT_W-1:0] duty_o
);
  pwm_cfg_t         act_q;
  pwm_cfg_t         next_cfg;
  logic [CNT_W-1:0] cnt_q;
  logic             half_q;
  logic             sync_q;
  logic [SW_W-1:0]  sync_left_q;
  logic             top_hit;
  logic             bottom_hit;
  logic             reload;

  always_comb begin
    top_hit    = !half_q && (cnt_q >= last_tick(act_q.period));
    bottom_hit = half_q && (cnt_q == '0);
    reload     = bottom_hit || (top_hit && dbl_i);
    next_cfg   = reload ? shadow_i : act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q       <= RST_CFG;
      cnt_q       <= '0;
      half_q      <= 1'b1;
      sync_q      <= 1'b0;
      sync_left_q <= '0;
    end else begin
      act_q <= next_cfg;
      if (bottom_hit) begin
        half_q <= 1'b0;
        cnt_q  <= '0;
      end else if (top_hit) begin
        half_q <= 1'b1;
        cnt_q  <= last_tick(next_cfg.period);
      end else if (half_q) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (reload) begin
        sync_q      <= 1'b1;
        sync_left_q <= next_cfg.sync_w;
      end else if (sync_q) begin
        if (sync_left_q == '0) sync_q <= 1'b0;
        else                   sync_left_q <= sync_left_q - 1'b1;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign half_o   = half_q;
  assign sync_o   = sync_q;
  assign period_o = act_q.period;
  assign dead_o   = act_q.dead;
  assign duty_o   = act_q.duty;
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg
  import pwm3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             live_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  input  logic             en_hi_i,
  input  logic             en_lo_i,
  output logic             hi_o,
  output logic             lo_o
);
  localparam int RUN_W = DT_W + 1;

  logic             want_hi;
  logic             side_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] guard;
  logic             settled;

  always_comb begin
    want_hi = cnt_i < duty_i;
    guard   = {dead_i, 1'b0};
    settled = run_q >= guard;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      side_q <= 1'b0;
      run_q  <= '0;
    end else begin
      side_q <= want_hi;
      if (want_hi != side_q)  run_q <= '0;
      else if (run_q != '1)   run_q <= run_q + 1'b1;
    end
  end

  assign hi_o = live_i & en_hi_i & side_q & settled;
  assign lo_o = live_i & en_lo_i & ~side_q & settled;
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter logic [CNT_W-1:0] PERIOD_RST = 16'd256,
  parameter logic [SW_W-1:0]  SYNCW_RST  = 8'd39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [NPH-1:0]    en_hi,
  input  logic [NPH-1:0]    en_lo,
  output logic [NPH-1:0]    pwm_hi,
  output logic [NPH-1:0]    pwm_lo,
  output logic              sync_o,
  output logic              half_o
);
  localparam pwm_cfg_t RST_CFG = '{
    period: PERIOD_RST,
    dead:   '0,
    sync_w: SYNCW_RST,
    duty:   '0
  };

  pwm_cfg_t                  shadow_cfg;
  logic                      mode_dbl;
  logic [CNT_W-1:0]          cnt_q;
  logic [CNT_W-1:0]          act_period;
  logic [DT_W-1:0]           act_dead;
  logic [NPH-1:0][CNT_W-1:0] act_duty;
  logic                      live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  pwm3_regfile #(.RST_CFG(RST_CFG)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .shadow_o (shadow_cfg),
    .dbl_o    (mode_dbl)
  );

  pwm3_timebase #(.RST_CFG(RST_CFG)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .shadow_i (shadow_cfg),
    .dbl_i    (mode_dbl),
    .cnt_o    (cnt_q),
    .half_o   (half_o),
    .sync_o   (sync_o),
    .period_o (act_period),
    .dead_o   (act_dead),
    .duty_o   (act_duty)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_leg
    pwm3_leg u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .live_i  (live_q),
      .cnt_i   (cnt_q),
      .duty_i  (act_duty[g]),
      .dead_i  (act_dead),
      .en_hi_i (en_hi[g]),
      .en_lo_i (en_lo[g]),
      .hi_o    (pwm_hi[g]),
      .lo_o    (pwm_lo[g])
    );
  end
endmodule

// File: rtl/pwm3_gen_chk.sv
module pwm3_gen_chk
  import pwm3_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic [NPH-1:0]            pwm_hi,
  input logic [NPH-1:0]            pwm_lo,
  input logic                      sync_o,
  input logic                      half_o,
  input logic                      mode_dbl,
  input logic [CNT_W-1:0]          cnt,
  input logic [CNT_W-1:0]          period_act,
  input logic [DT_W-1:0]           dead_act,
  input logic [NPH-1:0][CNT_W-1:0] duty_act
);
  for (genvar i = 0; i < NPH; i++) begin : g_ph
    // R13
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_hi[i] && pwm_lo[i]));
    // R5
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_hi[i]) && dead_act != '0) |-> !$past(pwm_lo[i]));
    // R5
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_lo[i]) && dead_act != '0) |-> !$past(pwm_hi[i]));
    // R4
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act[i] == '0 && $past(duty_act[i]) == '0) |-> !pwm_hi[i]);
  end

  // R7
  single_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_o) && !$past(mode_dbl)) |-> !half_o);
  // R11
  half_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(half_o) |-> ($past(cnt) == '0 && cnt == '0));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < period_act) || (cnt == '0));
endmodule

bind pwm3_gen pwm3_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwm_hi     (pwm_hi),
  .pwm_lo     (pwm_lo),
  .sync_o     (sync_o),
  .half_o     (half_o),
  .mode_dbl   (mode_dbl),
  .cnt        (cnt_q),
  .period_act (act_period),
  .dead_act   (act_dead),
  .duty_act   (act_duty)
);

// File: tb/pwm3_gen_bench.sv
module pwm3_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  en_hi = 3'b111;
  logic [2:0]  en_lo = 3'b111;
  logic [2:0]  pwm_hi, pwm_lo;
  logic        sync_o, half_o;
  logic [5:0]  sig;
  logic [5:0]  sig_d = '0;
  logic        sync_d = 1'b0;
  int          cyc = 0;
  int          nchk = 0;
  int          nfail = 0;

  always #5 clk = ~clk;

  pwm3_gen u_pwm3_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_hi(en_hi), .en_lo(en_lo), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .sync_o(sync_o), .half_o(half_o)
  );

  // index 0..2 high sides, 3..5 low sides
  assign sig = {pwm_lo, pwm_hi};

  always @(posedge clk) begin
    sig_d  <= sig;
    sync_d <= sync_o;
    cyc    <= cyc + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_sync(output int t, output logic h);
    do @(negedge clk); while (!(sync_o && !sync_d));
    t = cyc; h = half_o;
  endtask

  task automatic wait_start(output int t);
    logic h;
    do wait_sync(t, h); while (h);
  endtask

  task automatic wait_mid(output int t);
    logic h;
    do wait_sync(t, h); while (!h);
  endtask

  task automatic pulse_width(input int k, output int w);
    do @(negedge clk); while (!(sig[k] && !sig_d[k]));
    w = 0;
    while (sig[k]) begin w++; @(negedge clk); end
  endtask

  task automatic count_high(input int k, input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); h += int'(sig[k]); end
  endtask

  task automatic gap(input int off_k, input int on_k, output int g);
    do @(negedge clk); while (!(!sig[off_k] && sig_d[off_k]));
    g = 0;
    while (!sig[on_k]) begin g++; @(negedge clk); end
  endtask

  task automatic t_reset();
    int w;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 outputs in reset", int'(sig), 0);
    chk("R1 sync in reset", int'(sync_o), 0);
    chk("R1 status in reset", int'(half_o), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sync after release", int'(sync_o), 1);
    chk("R1 status after release", int'(half_o), 0);
    w = 0;
    while (sync_o) begin w++; @(negedge clk); end
    chk("R7 default sync width", w, 40);
  endtask

  task automatic t_config();
    int t1, t2, w;
    wr(0, 40); wr(1, 0); wr(2, 5); wr(3, 10); wr(4, 25); wr(5, 0);
    wait_start(t1);
    w = 0;
    while (sync_o) begin w++; @(negedge clk); end
    chk("R7 programmed sync width", w, 6);
    wait_start(t2);
    chk("R2 period spacing", t2 - t1, 80);
  endtask

  task automatic t_duty();
    int w;
    pulse_width(0, w); chk("R3 phase0 high width", w, 20);
    pulse_width(3, w); chk("R3 phase0 low width", w, 60);
    pulse_width(1, w); chk("R3 phase1 high width", w, 50);
    pulse_width(4, w); chk("R3 phase1 low width", w, 30);
    count_high(2, 160, w); chk("R4 zero duty high side", w, 0);
    count_high(5, 160, w); chk("R4 zero duty low side", w, 160);
    gap(3, 0, w); chk("R5 zero dead time gap", w, 0);
  endtask

  task automatic t_dead();
    int t, w;
    wr(1, 3);
    wait_start(t); wait_start(t);
    pulse_width(0, w); chk("R5 high width with dead time", w, 14);
    pulse_width(3, w); chk("R5 low width with dead time", w, 54);
    gap(3, 0, w); chk("R5 gap low off to high on", w, 6);
    gap(0, 3, w); chk("R5 gap high off to low on", w, 6);
  endtask

  task automatic t_suppress();
    int t, w;
    wr(3, 38); wr(4, 40);
    wait_start(t); wait_start(t);
    count_high(3, 240, w); chk("R6 short low pulse suppressed", w, 0);
    count_high(1, 240, w); chk("R4 full duty high side", w, 240);
    count_high(4, 240, w); chk("R4 full duty low side", w, 0);
  endtask

  task automatic t_enable();
    int w;
    en_hi[0] = 1'b0; en_lo[2] = 1'b0;
    count_high(0, 160, w); chk("R12 disabled high side", w, 0);
    count_high(5, 160, w); chk("R12 disabled low side", w, 0);
    count_high(1, 160, w); chk("R12 other output unaffected", w, 160);
    en_hi = 3'b111; en_lo = 3'b111;
    count_high(5, 80, w); chk("R12 re-enabled low side", w, 80);
  endtask

  task automatic t_single_update();
    int t, w;
    wr(1, 0); wr(3, 10);
    wait_start(t); wait_start(t);
    wait_start(t);
    wr(3, 20);
    pulse_width(0, w); chk("R8 straddling pulse old plus new", w, 30);
    pulse_width(0, w); chk("R8 next pulse new duty", w, 40);
  endtask

  task automatic t_double();
    int t1, t2, w;
    logic h1, h2;
    wr(6, 1);
    wait_sync(t1, h1);
    wait_sync(t1, h1); wait_sync(t2, h2);
    chk("R9 midpoint sync spacing", t2 - t1, 40);
    chk("R11 status alternates at syncs", int'(h1 != h2), 1);
    wait_mid(t1);
    w = 0;
    for (int i = 0; i < 40; i++) begin w += int'(half_o); @(negedge clk); end
    chk("R11 status high through second half", w, 40);
    chk("R11 status low at period start", int'(half_o), 0);
    wait_start(t1);
    wr(3, 10);
    wait_mid(t1);
    wr(3, 30);
    pulse_width(0, w); chk("R9 asymmetric straddling pulse", w, 40);
  endtask

  task automatic t_double_period();
    int t0, t1, t2;
    wait_start(t0);
    wr(0, 30);
    wait_mid(t1);
    chk("R10 first half keeps old period", t1 - t0, 40);
    wait_start(t2);
    chk("R10 second half uses new period", t2 - t1, 30);
  endtask

  task automatic t_min_period();
    int t1, t2;
    wr(6, 0); wr(2, 0); wr(0, 0);
    wait_start(t1); wait_start(t1);
    @(negedge clk);
    chk("R7 one-clock sync pulse", int'(sync_o), 0);
    wait_start(t2);
    chk("R2 zero period acts as one", t2 - t1, 2);
  endtask

  initial begin
    t_reset();
    t_config();
    t_duty();
    t_dead();
    t_suppress();
    t_enable();
    t_single_update();
    t_double();
    t_double_period();
    t_min_period();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule